// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block decodes bus write cycles into requests for a 64K x16 flash. Each write brings a 16-bit address and a 16-bit data word, marked by a one-cycle strobe from the bus interface. The decoder advances one step per strobe. Program, erase and ID-mode requests go to the array back end only after a fixed sequence of address/data pairs: a two-write unlock prefix, then a command code. Erase commands need the prefix a second time. A write that breaks a sequence sends the decoder back to plain read mode.

The decoder also reports the current mode. ID mode returns the two identification words on a separate read address. While the operation timer signals that an internal program or erase is running, the decoder ignores every write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `req_valid` is 0 and `id_word` is 0000.
- R2: When a command cycle is matched, only address bits 14..0 and data bits 7..0 are compared. Address bit 15 and data bits 15..8 have no effect.
- R3: The writes AA@5555, 55@2AAA and A0@5555, followed by one more write, issue `req_kind`=1 (program) with that last write's full 16-bit address and data. `req_valid` is high in the cycle after the last strobe.
- R4: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 10@5555 issue `req_kind`=3 (erase chip).
- R5: The same five-write prefix followed by data 30 at any address issues `req_kind`=2 (erase sector). `req_sector` equals address bits 15..11 of that write, so each sector holds 2K words.
- R6: The writes AA@5555, 55@2AAA and 90@5555 issue `req_kind`=4 and set `mode` to 1 (ID). In ID mode, `id_word` is 00BF for `rd_addr` 0, 2788 for `rd_addr` 1, and 0000 for any other address. Outside ID mode, `id_word` is 0000.
- R7: The writes AA@5555, 55@2AAA and F0@5555 issue `req_kind`=5 (exit ID) and return `mode` to 0.
- R8: A write of F0 at any address, when no sequence is in progress, issues `req_kind`=5 and returns `mode` to 0.
- R9: A write that does not match the expected cycle issues no request, restarts the sequence and leaves ID mode. The next write is then decoded as a first cycle.
- R10: While `busy_i` is high, `mode` is 2, and writes (the ID exit included) issue no request and change neither the sequence step nor ID mode. A sequence that was partly entered before busy continues once busy falls.
- R11: `req_valid` is a one-cycle pulse, and it is never raised in a cycle that does not follow an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle pulse marking a bus write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| busy_i | input | 1 | Internal operation in progress, from the operation timer |
| rd_addr | input | 16 | Read address used for ID words |
| mode | output | 2 | 0 read, 1 ID, 2 busy |
| id_word | output | 16 | Identification word for `rd_addr` in ID mode, else 0 |
| req_valid | output | 1 | Request pulse to the array back end |
| req_kind | output | 3 | 1 program, 2 erase sector, 3 erase chip, 4 enter ID, 5 exit ID |
| req_addr | output | 16 | Address of the request's final write |
| req_data | output | 16 | Data of the request's final write |
| req_sector | output | 5 | Sector number, address bits 15..11 |

## Verification
The bench drives matches with address bit 15 and the upper data byte set, to catch a decoder that compares full words. A decoder that did so would never unlock. It breaks sequences in the middle, in read mode and in ID mode, then sends the command code alone. A decoder that failed to restart would then issue a program, or stay in ID mode. It raises busy between the unlock prefix and the command and sends an F0 while busy. A design that aborted on busy would not enter ID mode afterwards, and one that obeyed commands while busy would issue an exit. The sector tests use sectors at both ends of the address space, which exposes a wrong bit slice.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_UNL1    = 3'd1,
    ST_UNL2    = 3'd2,
    ST_PGM_ARM = 3'd3,
    ST_ERS1    = 3'd4,
    ST_ERS2    = 3'd5,
    ST_ERS3    = 3'd6
  } step_e;

  typedef enum logic [2:0] {
    REQ_NONE     = 3'd0,
    REQ_PROGRAM  = 3'd1,
    REQ_SECTOR   = 3'd2,
    REQ_CHIP     = 3'd3,
    REQ_ID_ENTER = 3'd4,
    REQ_ID_EXIT  = 3'd5
  } req_e;

  localparam logic [1:0] MODE_READ = 2'd0;
  localparam logic [1:0] MODE_ID   = 2'd1;
  localparam logic [1:0] MODE_BUSY = 2'd2;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_ID_ENTER = 8'h90;
  localparam logic [7:0] CODE_ID_EXIT  = 8'hF0;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CMP_AW = 15,
  parameter int CMP_DW = 8,
  parameter logic [CMP_AW-1:0] PAT_A = 15'h5555,
  parameter logic [CMP_AW-1:0] PAT_B = 15'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              at_a,
  output logic              at_b,
  output logic [CMP_DW-1:0] code
);

  logic [CMP_AW-1:0] addr_cmp;

  assign addr_cmp = addr[CMP_AW-1:0];
  assign at_a     = (addr_cmp == PAT_A);
  assign at_b     = (addr_cmp == PAT_B);
  assign code     = data[CMP_DW-1:0];

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00BF,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h2788
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] id_word
);

  logic upper_zero;

  assign upper_zero = (rd_addr[ADDR_W-1:1] == '0);

  always_comb begin
    id_word = '0;
    if (enable && upper_zero) begin
      id_word = rd_addr[0] ? DEV_ID : MFR_ID;
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CMP_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_i,
  input  logic              at_a,
  input  logic              at_b,
  input  logic [CMP_DW-1:0] code,
  output logic              id_mode,
  output logic              req_valid,
  output req_e              req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);

  step_e step_q, step_d;
  logic  id_q, id_d;
  logic  fire;
  req_e  kind_d;
  logic  accept;

  assign accept = wr_stb && !busy_i;

  always_comb begin
    step_d = step_q;
    id_d   = id_q;
    fire   = 1'b0;
    kind_d = REQ_NONE;
    if (accept) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: begin
          if (at_a && code == CODE_UNLOCK_A) begin
            step_d = ST_UNL1;
          end else if (code == CODE_ID_EXIT) begin
            fire = 1'b1; kind_d = REQ_ID_EXIT; id_d = 1'b0;
          end else begin
            id_d = 1'b0;
          end
        end
        ST_UNL1: begin
          if (at_b && code == CODE_UNLOCK_B) step_d = ST_UNL2;
          else id_d = 1'b0;
        end
        ST_UNL2: begin
          if (at_a && code == CODE_PROGRAM) begin
            step_d = ST_PGM_ARM;
          end else if (at_a && code == CODE_ERASE) begin
            step_d = ST_ERS1;
          end else if (at_a && code == CODE_ID_ENTER) begin
            fire = 1'b1; kind_d = REQ_ID_ENTER; id_d = 1'b1;
          end else if (at_a && code == CODE_ID_EXIT) begin
            fire = 1'b1; kind_d = REQ_ID_EXIT; id_d = 1'b0;
          end else begin
            id_d = 1'b0;
          end
        end
        ST_PGM_ARM: begin
          fire = 1'b1; kind_d = REQ_PROGRAM;
        end
        ST_ERS1: begin
          if (at_a && code == CODE_UNLOCK_A) step_d = ST_ERS2;
          else id_d = 1'b0;
        end
        ST_ERS2: begin
          if (at_b && code == CODE_UNLOCK_B) step_d = ST_ERS3;
          else id_d = 1'b0;
        end
        ST_ERS3: begin
          if (code == CODE_SECTOR) begin
            fire = 1'b1; kind_d = REQ_SECTOR;
          end else if (at_a && code == CODE_CHIP) begin
            fire = 1'b1; kind_d = REQ_CHIP;
          end else begin
            id_d = 1'b0;
          end
        end
        default: id_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= ST_IDLE;
      id_q      <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= REQ_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      step_q    <= step_d;
      id_q      <= id_d;
      req_valid <= fire;
      if (fire) begin
        req_kind <= kind_d;
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  assign id_mode = id_q;

  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wr_stb) |=> !req_valid);  // R10
  AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(step_q) && $stable(id_q)));  // R10
  AST_REQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !req_valid);  // R11
  AST_ENTER_SETS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == REQ_ID_ENTER) |-> id_q);  // R6
  AST_EXIT_CLEARS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == REQ_ID_EXIT) |-> !id_q);  // R7

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECTOR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                busy_i,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [1:0]          mode,
  output logic [DATA_W-1:0]   id_word,
  output logic                req_valid,
  output logic [2:0]          req_kind,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [DATA_W-1:0]   req_data,
  output logic [SECTOR_W-1:0] req_sector
);

  localparam int CMP_AW = ADDR_W - 1;
  localparam int CMP_DW = 8;

  logic              rst_meta, rst_sync_n;
  logic              at_a, at_b;
  logic [CMP_DW-1:0] code;
  logic              id_mode;
  req_e              kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  flash_cmd_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_AW(CMP_AW), .CMP_DW(CMP_DW)
  ) u_match (
    .addr(wr_addr), .data(wr_data), .at_a(at_a), .at_b(at_b), .code(code)
  );

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_DW(CMP_DW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy_i), .at_a(at_a), .at_b(at_b),
    .code(code), .id_mode(id_mode), .req_valid(req_valid),
    .req_kind(kind), .req_addr(req_addr), .req_data(req_data)
  );

  flash_id_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_id (
    .enable(id_mode && !busy_i), .rd_addr(rd_addr), .id_word(id_word)
  );

  assign req_kind   = kind;
  assign req_sector = req_addr[ADDR_W-1 -: SECTOR_W];
  assign mode       = busy_i ? MODE_BUSY : (id_mode ? MODE_ID : MODE_READ);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode != 2'd3);  // R10

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [15:0] wr_addr, wr_data, rd_addr;
  logic        busy_i;
  logic [1:0]  mode;
  logic [15:0] id_word, req_addr, req_data;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [4:0]  req_sector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy_i), .rd_addr(rd_addr), .mode(mode),
    .id_word(id_word), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .req_sector(req_sector)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one strobe; returns at the negedge after the capturing edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock;
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
  endtask

  task automatic expect_req(input string tag, input logic [2:0] kind);
    check({tag, " valid"}, {15'd0, req_valid}, 16'd1);
    check({tag, " kind"}, {13'd0, req_kind}, {13'd0, kind});
  endtask

  task automatic t_reset;
    check("R1 mode", {14'd0, mode}, 16'd0);
    check("R1 valid", {15'd0, req_valid}, 16'd0);
    rd_addr = 16'd0; #1;
    check("R1 id_word", id_word, 16'h0000);
  endtask

  task automatic t_masked_program;
    wr(16'hD555, 16'h12AA);
    wr(16'hAAAA, 16'hFF55);
    wr(16'hD555, 16'h77A0);
    check("R2 no early req", {15'd0, req_valid}, 16'd0);
    wr(16'h8001, 16'h1234);
    expect_req("R2/R3 program", 3'd1);
    check("R3 addr", req_addr, 16'h8001);
    check("R3 data", req_data, 16'h1234);
    @(negedge clk);
    check("R11 pulse ends", {15'd0, req_valid}, 16'd0);
  endtask

  task automatic t_chip;
    unlock(); wr(16'h5555, 16'h0080); unlock(); wr(16'h5555, 16'h0010);
    expect_req("R4 chip", 3'd3);
  endtask

  task automatic t_sector;
    unlock(); wr(16'h5555, 16'h0080); unlock(); wr(16'hF800, 16'h0030);
    expect_req("R5 sector hi", 3'd2);
    check("R5 sector 31", {11'd0, req_sector}, 16'd31);
    unlock(); wr(16'h5555, 16'h0080); unlock(); wr(16'h0FFF, 16'h0030);
    expect_req("R5 sector lo", 3'd2);
    check("R5 sector 1", {11'd0, req_sector}, 16'd1);
  endtask

  task automatic t_id_and_exit3;
    unlock(); wr(16'h5555, 16'h0090);
    expect_req("R6 enter", 3'd4);
    check("R6 mode", {14'd0, mode}, 16'd1);
    rd_addr = 16'h0000; #1; check("R6 mfr", id_word, 16'h00BF);
    rd_addr = 16'h0001; #1; check("R6 dev", id_word, 16'h2788);
    rd_addr = 16'h0002; #1; check("R6 other", id_word, 16'h0000);
    unlock(); wr(16'h5555, 16'h00F0);
    expect_req("R7 exit", 3'd5);
    check("R7 mode", {14'd0, mode}, 16'd0);
    rd_addr = 16'h0000; #1; check("R6 read mode id_word", id_word, 16'h0000);
  endtask

  task automatic t_exit1;
    unlock(); wr(16'h5555, 16'h0090);
    wr(16'h4321, 16'h00F0);
    expect_req("R8 single exit", 3'd5);
    check("R8 mode", {14'd0, mode}, 16'd0);
  endtask

  task automatic t_abort;
    unlock(); wr(16'h5555, 16'h0077);
    check("R9 no req bad code", {15'd0, req_valid}, 16'd0);
    wr(16'h5555, 16'h00A0);
    wr(16'h0100, 16'h1234);
    check("R9 no program after abort", {15'd0, req_valid}, 16'd0);
    wr(16'h5555, 16'h00AA); wr(16'h2AAB, 16'h0055); wr(16'h5555, 16'h0090);
    check("R9 wrong addr no enter", {14'd0, mode}, 16'd0);
    unlock(); wr(16'h5555, 16'h0090);
    wr(16'h0000, 16'h0033);
    check("R9 id left", {14'd0, mode}, 16'd0);
    check("R9 no req in id", {15'd0, req_valid}, 16'd0);
  endtask

  task automatic t_busy;
    unlock();
    @(negedge clk); busy_i = 1'b1; #1;
    check("R10 mode busy", {14'd0, mode}, 16'd2);
    wr(16'h5555, 16'h0033);
    check("R10 no req", {15'd0, req_valid}, 16'd0);
    @(negedge clk); busy_i = 1'b0;
    wr(16'h5555, 16'h0090);
    expect_req("R10 sequence kept", 3'd4);
    check("R10 id after busy", {14'd0, mode}, 16'd1);
    @(negedge clk); busy_i = 1'b1;
    wr(16'h1111, 16'h00F0);
    check("R10 exit ignored", {15'd0, req_valid}, 16'd0);
    @(negedge clk); busy_i = 1'b0; #1;
    check("R10 still id", {14'd0, mode}, 16'd1);
    wr(16'h0000, 16'h00F0);
    expect_req("R8 exit", 3'd5);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    busy_i = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_masked_program();
    t_chip();
    t_sector();
    t_id_and_exit3();
    t_exit1();
    t_abort();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule